// File: doc/BRIEF.md
# Short-Transfer Report Queue

This block keeps a record of transfers that finished before their programmed length, for example because a streaming source marked the end of a packet early. Each time the datapath signals such an early end for a transfer whose reporting option was set, the block stores the transfer's ID together with the number of bytes that were actually moved. Software drains these records through a pair of read-only registers. It reads the byte count first and then the ID. Reading the ID removes the record.

The most significant bit of the completion word tells software whether any record is still waiting. The other bits of that word carry the per-ID completion mask from the surrounding controller unchanged. A status word gives the current fill level and a sticky flag that marks a record lost because the queue was full. Reading the status word clears that flag.

Top module: `prt_report_fifo`

## Requirements
- R1: After reset the queue is empty, completion word bit 31 is 0, and the status word reads 0.
- R2: An early-end event is stored only when `ev_report_en` is 1 in the same cycle as `ev_valid`. An event with `ev_report_en` at 0 leaves the fill level and the pending flag unchanged.
- R3: A read of the length register returns the byte count of the oldest record, zero-extended to 32 bits, and does not remove it. Two length reads in a row return the same value.
- R4: A read of the ID register returns the oldest record's ID, zero-extended to 32 bits, and removes that record. Records come out in the order they arrived.
- R5: Completion word bit 31 is 1 exactly while at least one record is stored. Bits 30..0 equal `cmpl_mask[30:0]`.
- R6: A read of the length or ID register while the queue is empty returns 0 and changes neither the fill level nor the overflow flag.
- R7: An enabled event that arrives while the queue holds DEPTH records, with no ID read in that cycle, is discarded. The stored records are left intact and the overflow flag is set.
- R8: The overflow flag stays set until a status read. A status read returns the flag's value from before the read and clears it, unless a new discard happens in the same cycle, in which case the flag stays set.
- R9: When the queue is full and an ID read and an enabled event fall in the same cycle, the oldest record is returned and removed and the new record is accepted. No overflow is flagged.
- R10: The status word holds the overflow flag in bit 0 and the fill level in bits 15..8. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Early-end event from the datapath, one cycle per event |
| ev_report_en | input | 1 | Reporting option of the transfer that ended early |
| ev_id | input | ID_W | ID of the transfer that ended early |
| ev_len | input | LEN_W | Bytes actually moved by that transfer |
| cmpl_mask | input | 31 | Per-ID completion mask from the controller |
| rd_len_stb | input | 1 | Read strobe for the length register |
| rd_id_stb | input | 1 | Read strobe for the ID register; pops the record |
| rd_stat_stb | input | 1 | Read strobe for the status word; clears overflow |
| len_rdata | output | 32 | Length register read data, valid the cycle after the strobe |
| id_rdata | output | 32 | ID register read data, valid the cycle after the strobe |
| stat_rdata | output | 32 | Status word read data, valid the cycle after the strobe |
| done_word | output | 32 | Completion word: pending flag in bit 31, mask below |

## Verification
Two situations can land in the same cycle. In the first, a pop by an ID read coincides with a push from an early-end event. The bench fills the queue to DEPTH and then asserts `rd_id_stb` and an enabled `ev_valid` together. It judges the cycle by the ID that comes back, by a fill level of DEPTH afterwards, by an overflow flag that stays clear, and by the full drain order against the scoreboard. In the second, a discard coincides with a status read. The bench issues the read and an overflowing event in the same cycle. That read must return the old flag, and a later status read must show it set.

// File: rtl/prt_pkg.sv
// Package: shared constants for the short-transfer report queue.
// Assumes 32-bit software-visible registers.
package prt_pkg;
    localparam int REG_W        = 32;
    localparam int DONE_PEND_B  = 31;   // pending flag position in the completion word
    localparam int STAT_OVF_B   = 0;    // overflow flag position in the status word
    localparam int STAT_CNT_LSB = 8;    // fill level field, bits 15..8
    localparam int STAT_CNT_W   = 8;
endpackage

// File: rtl/prt_fifo_store.sv
// Module: register-based FIFO holding {id, len} records.
// Assumes the caller gates push against full (pop in the same cycle frees a slot)
// and never pops while empty.
module prt_fifo_store #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 27
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [ENT_W-1:0]              wr_ent,
    output logic [ENT_W-1:0]              head_ent,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          empty,
    output logic                          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ENT_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);
    assign head_ent = slot[rd_ptr];

    // One write-enabled register per slot.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[g] <= '0;
                else if (push && (wr_ptr == PTR_W'(g)))
                    slot[g] <= wr_ent;
            end
        end
    endgenerate

    // Pointer advance with explicit wrap so any DEPTH works.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Fill level tracks pushes minus pops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (push && !pop)
            count <= count + 1'b1;
        else if (pop && !push)
            count <= count - 1'b1;
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_pop_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == $past(count) - 1'b1));

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> $stable(count));
endmodule

// File: rtl/prt_ovf_tracker.sv
// Module: sticky overflow flag, cleared by a status read.
// Assumes drop pulses once per discarded record; a drop in the clearing cycle wins.
module prt_ovf_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    output logic ovf
);
    // Set has priority over clear so no discard goes unreported.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
        else if (clr)
            ovf <= 1'b0;
    end

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf);
endmodule

// File: rtl/prt_readout.sv
// Module: registered read data for the length, ID and status registers.
// Assumes strobes are single-cycle; data holds until the next strobe of that register.
module prt_readout #(
    parameter int ID_W  = 5,
    parameter int LEN_W = 24,
    parameter int CNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_len_stb,
    input  logic                    rd_id_stb,
    input  logic                    rd_stat_stb,
    input  logic                    empty,
    input  logic [ID_W-1:0]         head_id,
    input  logic [LEN_W-1:0]        head_len,
    input  logic [CNT_W-1:0]        count,
    input  logic                    ovf,
    output logic [prt_pkg::REG_W-1:0] len_rdata,
    output logic [prt_pkg::REG_W-1:0] id_rdata,
    output logic [prt_pkg::REG_W-1:0] stat_rdata
);
    import prt_pkg::*;

    logic [REG_W-1:0] stat_word;

    // Assemble the status word from its fields.
    always_comb begin
        stat_word = '0;
        stat_word[STAT_OVF_B] = ovf;
        stat_word[STAT_CNT_LSB +: STAT_CNT_W] = STAT_CNT_W'(count);
    end

    // Capture the length of the head record, or zero when empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_rdata <= '0;
        else if (rd_len_stb)
            len_rdata <= empty ? '0 : REG_W'(head_len);
    end

    // Capture the ID of the head record, or zero when empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_rdata <= '0;
        else if (rd_id_stb)
            id_rdata <= empty ? '0 : REG_W'(head_id);
    end

    // Capture the status word as it stood before this cycle's updates.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_rdata <= '0;
        else if (rd_stat_stb)
            stat_rdata <= stat_word;
    end

    assert_empty_id_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id_stb && empty) |=> (id_rdata == '0));

    assert_empty_len_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_len_stb && empty) |=> (len_rdata == '0));
endmodule

// File: rtl/prt_report_fifo.sv
// Module: top of the short-transfer report queue.
// Stores {id, len} for transfers that ended early with reporting enabled,
// pops on ID reads, flags pending records in bit 31 of the completion word,
// and tracks discards in a sticky overflow flag.
// Assumes DEPTH fits in the 8-bit status fill field.
module prt_report_fifo #(
    parameter int DEPTH = 8,
    parameter int ID_W  = 5,
    parameter int LEN_W = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_valid,
    input  logic                      ev_report_en,
    input  logic [ID_W-1:0]           ev_id,
    input  logic [LEN_W-1:0]          ev_len,
    input  logic [30:0]               cmpl_mask,
    input  logic                      rd_len_stb,
    input  logic                      rd_id_stb,
    input  logic                      rd_stat_stb,
    output logic [31:0]               len_rdata,
    output logic [31:0]               id_rdata,
    output logic [31:0]               stat_rdata,
    output logic [31:0]               done_word
);
    import prt_pkg::*;

    localparam int ENT_W = ID_W + LEN_W;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic             empty, full;
    logic [CNT_W-1:0] count;
    logic [ENT_W-1:0] head_ent;
    logic             ev_take, push, pop, drop, ovf;

    // Qualify events and resolve push, pop and discard for this cycle.
    always_comb begin
        ev_take = ev_valid && ev_report_en;
        pop     = rd_id_stb && !empty;
        push    = ev_take && (!full || pop);
        drop    = ev_take && full && !pop;
    end

    prt_fifo_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .wr_ent   ({ev_id, ev_len}),
        .head_ent (head_ent),
        .count    (count),
        .empty    (empty),
        .full     (full)
    );

    prt_ovf_tracker u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (drop),
        .clr   (rd_stat_stb),
        .ovf   (ovf)
    );

    prt_readout #(.ID_W(ID_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_len_stb  (rd_len_stb),
        .rd_id_stb   (rd_id_stb),
        .rd_stat_stb (rd_stat_stb),
        .empty       (empty),
        .head_id     (head_ent[ENT_W-1:LEN_W]),
        .head_len    (head_ent[LEN_W-1:0]),
        .count       (count),
        .ovf         (ovf),
        .len_rdata   (len_rdata),
        .id_rdata    (id_rdata),
        .stat_rdata  (stat_rdata)
    );

    // Completion word: pending flag over the pass-through mask.
    always_comb begin
        done_word = {1'b0, cmpl_mask};
        done_word[DONE_PEND_B] = !empty;
    end

    assert_pending_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_word[DONE_PEND_B] == (count != '0));

    assert_disabled_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_report_en && !rd_id_stb) |=> $stable(count));

    assert_swap_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_id_stb && ev_take) |=> (full && !drop_seen_q));

    logic drop_seen_q;
    // Remember a discard for the swap check.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_seen_q <= 1'b0;
        else        drop_seen_q <= drop;
    end
endmodule

// File: tb/prt_report_fifo_bench.sv
`timescale 1ns/1ps
module prt_report_fifo_bench;
    localparam int DEPTH = 8;
    localparam int ID_W  = 5;
    localparam int LEN_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_valid = 1'b0, ev_report_en = 1'b0;
    logic [ID_W-1:0]   ev_id = '0;
    logic [LEN_W-1:0]  ev_len = '0;
    logic [30:0]       cmpl_mask = '0;
    logic              rd_len_stb = 1'b0, rd_id_stb = 1'b0, rd_stat_stb = 1'b0;
    logic [31:0]       len_rdata, id_rdata, stat_rdata, done_word;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];   // scoreboard: {id in [31:24], len in [23:0]}

    always #4 clk = ~clk;    // 125 MHz

    prt_report_fifo #(.DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W)) u_prt_report_fifo (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_report_en(ev_report_en),
        .ev_id(ev_id), .ev_len(ev_len), .cmpl_mask(cmpl_mask),
        .rd_len_stb(rd_len_stb), .rd_id_stb(rd_id_stb), .rd_stat_stb(rd_stat_stb),
        .len_rdata(len_rdata), .id_rdata(id_rdata), .stat_rdata(stat_rdata),
        .done_word(done_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Driver: one enabled or disabled event; pushes to the scoreboard per R2/R7.
    task automatic drive_event(input logic en, input logic [ID_W-1:0] id, input logic [LEN_W-1:0] len);
        ev_valid = 1'b1; ev_report_en = en; ev_id = id; ev_len = len;
        if (en && exp_q.size() < DEPTH) exp_q.push_back({3'b0, id, len});
        @(negedge clk);
        ev_valid = 1'b0; ev_report_en = 1'b0;
    endtask

    task automatic read_stat(output logic [31:0] v);
        rd_stat_stb = 1'b1; @(negedge clk); rd_stat_stb = 1'b0; v = stat_rdata;
    endtask

    task automatic read_len(output logic [31:0] v);
        rd_len_stb = 1'b1; @(negedge clk); rd_len_stb = 1'b0; v = len_rdata;
    endtask

    task automatic read_id(output logic [31:0] v);
        rd_id_stb = 1'b1; @(negedge clk); rd_id_stb = 1'b0; v = id_rdata;
    endtask

    function automatic logic [31:0] stat_of(input int cnt, input logic o);
        return {16'b0, 8'(cnt), 7'b0, o};
    endfunction

    // Monitor: pop one record and compare it with the scoreboard head (R3, R4).
    task automatic pop_compare(input string req);
        logic [31:0] l, i, e;
        e = exp_q.pop_front();
        read_len(l);
        check({req, " len"}, l, {8'b0, e[23:0]});
        read_id(i);
        check({req, " id"}, i, {27'b0, e[28:24]});
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) pop_compare(req);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 done_word", done_word, 32'h0);
        read_stat(v);
        check("R1 status", v, 32'h0);

        // R6: empty reads return zero and change nothing
        read_len(v);  check("R6 empty len", v, 32'h0);
        read_id(v);   check("R6 empty id", v, 32'h0);
        read_stat(v); check("R6 status after empty reads", v, stat_of(0, 1'b0));

        // R2: disabled event is ignored
        drive_event(1'b0, 5'd3, 24'd100);
        check("R2 pending after disabled event", {31'b0, done_word[31]}, 32'h0);
        read_stat(v); check("R2 count after disabled event", v, stat_of(0, 1'b0));

        // R5: pending flag and mask pass-through
        cmpl_mask = 31'h1234_5678;
        drive_event(1'b1, 5'd1, 24'd17);
        drive_event(1'b1, 5'd30, 24'hABCDEF);
        drive_event(1'b1, 5'd7, 24'd1);
        check("R5 done_word", done_word, {1'b1, 31'h1234_5678});
        read_stat(v); check("R10 status fields", v, stat_of(3, 1'b0));

        // R3: length read does not pop
        read_len(v); read_len(v2);
        check("R3 repeated length read", v2, v);
        check("R3 length is head", v, 32'd17);

        // R4: in-order drain
        drain("R4");
        check("R5 pending clear after drain", {31'b0, done_word[31]}, 32'h0);

        // R7: overflow discards, leaves contents intact
        for (int k = 0; k < DEPTH; k++) drive_event(1'b1, 5'(k + 10), 24'(k * 3 + 5));
        drive_event(1'b1, 5'd31, 24'd999);
        read_stat(v); check("R7 overflow and full count", v, stat_of(DEPTH, 1'b1));
        read_stat(v); check("R8 overflow cleared by status read", v, stat_of(DEPTH, 1'b0));
        drain("R7");

        // R9: full queue, pop and push in the same cycle
        for (int k = 0; k < DEPTH; k++) drive_event(1'b1, 5'(k), 24'(k + 200));
        v2 = exp_q.pop_front();
        exp_q.push_back({3'b0, 5'd21, 24'd4242});
        ev_valid = 1'b1; ev_report_en = 1'b1; ev_id = 5'd21; ev_len = 24'd4242;
        rd_id_stb = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; ev_report_en = 1'b0; rd_id_stb = 1'b0;
        check("R9 popped id", id_rdata, {27'b0, v2[28:24]});
        read_stat(v); check("R9 full and no overflow", v, stat_of(DEPTH, 1'b0));

        // R8: discard in the same cycle as a status read keeps the flag
        ev_valid = 1'b1; ev_report_en = 1'b1; ev_id = 5'd9; ev_len = 24'd9;
        rd_stat_stb = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; ev_report_en = 1'b0; rd_stat_stb = 1'b0;
        check("R8 read returns old flag", stat_rdata, stat_of(DEPTH, 1'b0));
        read_stat(v); check("R8 flag set by concurrent drop", v, stat_of(DEPTH, 1'b1));
        drain("R9");

        // R6: empty ID read after drain leaves overflow and count alone
        drive_event(1'b1, 5'd2, 24'd2);
        drain("R4");
        read_id(v); check("R6 empty id after drain", v, 32'h0);
        read_stat(v); check("R6 status after empty pop", v, stat_of(0, 1'b0));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule